// File: doc/BRIEF.md
# Descriptor Ring DMA Pipe

This block is one DMA pipe driven by a circular ring of 8-byte descriptors held in system memory. Software places descriptors in the ring, programs the ring base and size, and then hands work to the pipe by writing a producer byte offset into an event register. The pipe walks the ring from its own consumer offset. For each descriptor it fetches the two descriptor words and then moves the buffer it describes, either from memory out to a peripheral stream or from a peripheral stream into memory. It stops once the consumer offset equals the producer offset.

A small word-addressed register port gives control (enable, direction, system mode), a pipe reset, a halt, interrupt status with enables, and a read-back of the consumer offset. Memory is reached through a single request port that holds each request until it is acknowledged. The peripheral side is a pair of valid/ready word streams, one for each direction.

Register word indices on `reg_addr`: 0 control, 1 pipe reset, 2 halt, 3 interrupt status, 4 interrupt enable, 5 ring base, 6 ring size in bytes, 7 producer offset (event), 8 consumer offset (read only).

Top module: `dring_pipe`

## Requirements
- R1: After `rst_n` is low for a clock edge, every register reads 0, `irq` is 0, `mem_req` is 0 and `tx_valid` is 0.
- R2: For each descriptor at ring offset o, the pipe reads the word at base+o as the buffer address. It then reads the word at base+o+4, taking bits 15:0 as the byte count and bits 31:16 as the flags.
- R3: With control bit 3 clear, a descriptor moves ceil(count/4) words. Each word is read from memory at ascending addresses starting at the buffer address and is sent on `tx_data`. `tx_last` is 1 only on the final word, and only when flag bit 13 or flag bit 14 is set.
- R4: With control bit 3 set, ceil(count/4) words are taken from the receive stream and written to memory at ascending addresses starting at the buffer address.
- R5: A write of a valid offset to index 7 sets the producer offset. The pipe processes descriptors until its consumer offset (index 8, low 16 bits) equals the producer offset. The consumer offset advances by 8 per descriptor and wraps to 0 when it reaches the ring size.
- R6: A descriptor with a byte count of 0 completes without any memory data access or stream beat.
- R7: A write to index 7 whose value is not a multiple of 8, or is not below the ring size, sets status bit 4 and leaves the producer offset unchanged.
- R8: When a descriptor completes, status bit 0 is set if its flag bit 15 is set, and status bit 5 is set if its flag bit 14 is set. Status bit 3 is set when a completion makes the consumer offset equal to the producer offset. Writing 1 to a status bit clears it. `irq` is the OR of status ANDed with the enables at index 4.
- R9: While halt (index 2 bit 0) is 1, no new descriptor is started and the consumer offset holds. Writing 0 resumes from the same offset.
- R10: Writing 1 and then 0 to the pipe reset register (index 1 bit 0) returns all other registers and the consumer offset to their reset values.
- R11: While control bit 1 (enable) is 0, the pipe starts no descriptor.
- R12: `mem_req`, with its address and data, is held until `mem_ack`. `tx_valid`, with its data, is held until `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Outgoing stream word valid |
| tx_ready | input | 1 | Outgoing stream accepts |
| tx_data | output | 32 | Outgoing stream word |
| tx_last | output | 1 | Final word of a block or transfer |
| rx_valid | input | 1 | Incoming stream word valid |
| rx_ready | output | 1 | Pipe accepts incoming word |
| rx_data | input | 32 | Incoming stream word |
| irq | output | 1 | Pipe interrupt |

## Verification
The bench builds the pipe with its default parameters: 32-bit addresses, 16-bit ring offsets and 16-bit byte counts. It programs a ring of only 32 bytes, so four descriptors are enough to reach the wrap back to offset 0, and a producer value of 0x20 falls just outside the ring as the boundary of the invalid-event check. Throttling the outgoing stream every other cycle brings the hold rules into play while the data order is checked.

// File: rtl/dring_pkg.sv
// Shared types and constants for the descriptor ring pipe.
// Assumes a 32-bit register port and 32-bit data beats.
package dring_pkg;

    typedef enum logic [2:0] {
        E_IDLE, E_DADR, E_DCTL, E_RD, E_TX, E_RX, E_WR, E_DONE
    } eng_st_t;

    localparam int DESC_CNT_W = 16;   // byte-count field width
    localparam int BEAT_BYTES = 4;

    // register word indices
    localparam logic [3:0] RA_CTRL = 4'd0;
    localparam logic [3:0] RA_RST  = 4'd1;
    localparam logic [3:0] RA_HALT = 4'd2;
    localparam logic [3:0] RA_STAT = 4'd3;
    localparam logic [3:0] RA_IEN  = 4'd4;
    localparam logic [3:0] RA_BASE = 4'd5;
    localparam logic [3:0] RA_SIZE = 4'd6;
    localparam logic [3:0] RA_EVT  = 4'd7;
    localparam logic [3:0] RA_CONS = 4'd8;

    // control bits
    localparam int CT_EN  = 1;
    localparam int CT_DIR = 3;
    localparam int CT_SYS = 5;

    // descriptor flag bits
    localparam int FL_INT = 15;
    localparam int FL_EOT = 14;
    localparam int FL_EOB = 13;

    // status bits
    localparam int ST_DESC = 0;
    localparam int ST_OOD  = 3;
    localparam int ST_ERR  = 4;
    localparam int ST_EOT  = 5;
    localparam int ST_W    = 6;

endpackage

// File: rtl/dring_wrap.sv
// Ring offset stepper: gives the offset of the next descriptor slot.
// Assumes the ring size is a non-zero multiple of 8.
module dring_wrap #(
    parameter int OW = 16
) (
    input  logic [OW-1:0] ofs,
    input  logic [OW-1:0] size,
    output logic [OW-1:0] nxt
);
    logic [OW:0] sum;

    // step by one descriptor, fold back to zero at the ring end
    always_comb begin
        sum = {1'b0, ofs} + (OW+1)'(8);
        nxt = (sum >= {1'b0, size}) ? '0 : sum[OW-1:0];
    end
endmodule

// File: rtl/dring_regs.sv
// Register file of the pipe: control, pipe reset, halt, status (W1C),
// enables, ring base and size, producer offset and its validity check.
// Assumes one write per cycle; reads are combinational.
module dring_regs
    import dring_pkg::*;
#(
    parameter int AW = 32,
    parameter int OW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen,
    input  logic [3:0]    addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    input  logic [OW-1:0] cons,
    input  logic          ev_desc,
    input  logic          ev_eot,
    input  logic          ev_ood,
    output logic          soft_clr,
    output logic          ctrl_en,
    output logic          ctrl_dir,
    output logic          halt,
    output logic [AW-1:0] base,
    output logic [OW-1:0] size,
    output logic [OW-1:0] prod,
    output logic [ST_W-1:0] stat,
    output logic          irq
);
    localparam logic [5:0]      CTRL_MASK = 6'b101010;
    localparam logic [ST_W-1:0] STAT_MASK = 6'b111001;

    logic            rst_q, halt_q;
    logic [5:0]      ctrl_q;
    logic [ST_W-1:0] stat_q, ien_q, stat_set;
    logic [AW-1:0]   base_q;
    logic [OW-1:0]   size_q, prod_q;
    logic            evt_wr, evt_ok;

    assign evt_wr = wen && (addr == RA_EVT);

    // producer value must be 8-aligned and inside the ring
    assign evt_ok = (wdata[2:0] == 3'd0) && ((wdata >> OW) == '0) &&
                    (wdata[OW-1:0] < size_q);

    // status events raised this cycle
    always_comb begin
        stat_set          = '0;
        stat_set[ST_DESC] = ev_desc;
        stat_set[ST_EOT]  = ev_eot;
        stat_set[ST_OOD]  = ev_ood;
        stat_set[ST_ERR]  = evt_wr && !evt_ok;
    end

    // pipe reset register, kept apart so it can release the others
    always_ff @(posedge clk) begin
        if (!rst_n)                       rst_q <= 1'b0;
        else if (wen && addr == RA_RST)   rst_q <= wdata[0];
    end

    // all other registers, held at defaults while the pipe reset is set
    always_ff @(posedge clk) begin
        if (!rst_n || rst_q) begin
            ctrl_q <= '0; halt_q <= 1'b0; stat_q <= '0; ien_q <= '0;
            base_q <= '0; size_q <= '0; prod_q <= '0;
        end else begin
            if (wen && addr == RA_CTRL) ctrl_q <= wdata[5:0] & CTRL_MASK;
            if (wen && addr == RA_HALT) halt_q <= wdata[0];
            if (wen && addr == RA_IEN)  ien_q  <= wdata[ST_W-1:0] & STAT_MASK;
            if (wen && addr == RA_BASE) base_q <= {wdata[AW-1:3], 3'b000};
            if (wen && addr == RA_SIZE) size_q <= wdata[OW-1:0];
            if (evt_wr && evt_ok)       prod_q <= wdata[OW-1:0];
            if (wen && addr == RA_STAT)
                stat_q <= (stat_q & ~wdata[ST_W-1:0]) | stat_set;
            else
                stat_q <= stat_q | stat_set;
        end
    end

    // read multiplexer
    always_comb begin
        unique case (addr)
            RA_CTRL: rdata = 32'(ctrl_q);
            RA_RST:  rdata = 32'(rst_q);
            RA_HALT: rdata = 32'(halt_q);
            RA_STAT: rdata = 32'(stat_q);
            RA_IEN:  rdata = 32'(ien_q);
            RA_BASE: rdata = 32'(base_q);
            RA_SIZE: rdata = 32'(size_q);
            RA_EVT:  rdata = 32'(prod_q);
            RA_CONS: rdata = 32'(cons);
            default: rdata = '0;
        endcase
    end

    assign soft_clr = rst_q;
    assign ctrl_en  = ctrl_q[CT_EN];
    assign ctrl_dir = ctrl_q[CT_DIR];
    assign halt     = halt_q;
    assign base     = base_q;
    assign size     = size_q;
    assign prod     = prod_q;
    assign stat     = stat_q;
    assign irq      = |(stat_q & ien_q);
endmodule

// File: rtl/dring_engine.sv
// Descriptor engine: fetches each descriptor, moves its buffer word by
// word in the selected direction, then advances the consumer offset.
// Assumes memory holds a request until it acknowledges, with read data
// valid in the acknowledge cycle. Halt is honoured between descriptors.
module dring_engine
    import dring_pkg::*;
#(
    parameter int AW = 32,
    parameter int OW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          dir,
    input  logic          halt,
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] size,
    input  logic [OW-1:0] prod,
    output logic [OW-1:0] cons,
    output logic          idle,
    output logic          ev_desc,
    output logic          ev_eot,
    output logic          ev_ood,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [31:0]   tx_data,
    output logic          tx_last,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic [31:0]   rx_data
);
    localparam int BW = DESC_CNT_W - 1;   // beat counter width

    eng_st_t          st;
    logic [OW-1:0]    cons_q, nxt_ofs;
    logic [AW-1:0]    buf_addr;
    logic [15:0]      flags;
    logic [BW-1:0]    beats;
    logic [31:0]      data_q;
    logic             dir_q;
    logic [DESC_CNT_W:0] cnt_p3;

    dring_wrap #(.OW(OW)) u_wrap (.ofs(cons_q), .size(size), .nxt(nxt_ofs));

    // rounded-up beat count of the descriptor word being fetched
    assign cnt_p3 = {1'b0, mem_rdata[DESC_CNT_W-1:0]} + (DESC_CNT_W+1)'(BEAT_BYTES-1);

    // output decode from state
    always_comb begin
        mem_req   = (st == E_DADR) || (st == E_DCTL) || (st == E_RD) || (st == E_WR);
        mem_we    = (st == E_WR);
        unique case (st)
            E_DADR:     mem_addr = base + AW'(cons_q);
            E_DCTL:     mem_addr = base + AW'(cons_q) + AW'(4);
            E_RD, E_WR: mem_addr = buf_addr;
            default:    mem_addr = '0;
        endcase
        mem_wdata = data_q;
        tx_valid  = (st == E_TX);
        tx_data   = data_q;
        tx_last   = (st == E_TX) && (beats == BW'(1)) && (flags[FL_EOB] || flags[FL_EOT]);
        rx_ready  = (st == E_RX);
        ev_desc   = (st == E_DONE) && flags[FL_INT];
        ev_eot    = (st == E_DONE) && flags[FL_EOT];
        ev_ood    = (st == E_DONE) && (nxt_ofs == prod);
        idle      = (st == E_IDLE);
    end

    // descriptor sequencing
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st <= E_IDLE; cons_q <= '0; buf_addr <= '0; flags <= '0;
            beats <= '0; data_q <= '0; dir_q <= 1'b0;
        end else begin
            unique case (st)
                E_IDLE: if (en && !halt && cons_q != prod) st <= E_DADR;
                E_DADR: if (mem_ack) begin
                    buf_addr <= mem_rdata[AW-1:0];
                    st       <= E_DCTL;
                end
                E_DCTL: if (mem_ack) begin
                    flags <= mem_rdata[31:16];
                    beats <= cnt_p3[DESC_CNT_W:2];
                    dir_q <= dir;
                    if (mem_rdata[DESC_CNT_W-1:0] == '0) st <= E_DONE;
                    else if (dir)                        st <= E_RX;
                    else                                 st <= E_RD;
                end
                E_RD: if (mem_ack) begin
                    data_q <= mem_rdata;
                    st     <= E_TX;
                end
                E_TX: if (tx_ready) begin
                    beats    <= beats - BW'(1);
                    buf_addr <= buf_addr + AW'(BEAT_BYTES);
                    st       <= (beats == BW'(1)) ? E_DONE : E_RD;
                end
                E_RX: if (rx_valid) begin
                    data_q <= rx_data;
                    st     <= E_WR;
                end
                E_WR: if (mem_ack) begin
                    beats    <= beats - BW'(1);
                    buf_addr <= buf_addr + AW'(BEAT_BYTES);
                    st       <= (beats == BW'(1)) ? E_DONE : E_RX;
                end
                E_DONE: begin
                    cons_q <= nxt_ofs;
                    st     <= E_IDLE;
                end
                default: st <= E_IDLE;
            endcase
        end
    end

    assign cons = cons_q;
endmodule

// File: rtl/dring_pipe.sv
// Top of the descriptor ring DMA pipe: joins the register file and the
// descriptor engine. Assumes one pipe per instance and no arbitration.
module dring_pipe
    import dring_pkg::*;
#(
    parameter int AW = 32,
    parameter int OW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wen,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [31:0]   tx_data,
    output logic          tx_last,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic [31:0]   rx_data,
    output logic          irq
);
    logic            soft_clr, ctrl_en, ctrl_dir, halt_on, eng_idle;
    logic            ev_desc, ev_eot, ev_ood;
    logic [AW-1:0]   ring_base;
    logic [OW-1:0]   ring_size, prod_ofs, cons_ofs;
    logic [ST_W-1:0] stat_bits;

    dring_regs #(.AW(AW), .OW(OW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .cons(cons_ofs),
        .ev_desc(ev_desc), .ev_eot(ev_eot), .ev_ood(ev_ood),
        .soft_clr(soft_clr), .ctrl_en(ctrl_en), .ctrl_dir(ctrl_dir),
        .halt(halt_on), .base(ring_base), .size(ring_size),
        .prod(prod_ofs), .stat(stat_bits), .irq(irq)
    );

    dring_engine #(.AW(AW), .OW(OW)) u_eng (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .en(ctrl_en),
        .dir(ctrl_dir), .halt(halt_on), .base(ring_base), .size(ring_size),
        .prod(prod_ofs), .cons(cons_ofs), .idle(eng_idle),
        .ev_desc(ev_desc), .ev_eot(ev_eot), .ev_ood(ev_ood),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data)
    );
endmodule

// File: rtl/dring_pipe_chk.sv
// Property checker for dring_pipe, attached by bind. Observes ports and
// the nets that join the register file to the engine.
module dring_pipe_chk #(
    parameter int AW = 32,
    parameter int OW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_clr,
    input logic          reg_wen,
    input logic [3:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          halt_on,
    input logic          ctrl_en,
    input logic          eng_idle,
    input logic [OW-1:0] cons_ofs,
    input logic [OW-1:0] prod_ofs,
    input logic [5:0]    stat_bits,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [31:0]   tx_data
);
    logic bad_evt;
    assign bad_evt = reg_wen && (reg_addr == 4'd7) && (reg_wdata[2:0] != 3'd0);

    AST_OFS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_ofs != $past(cons_ofs)) |-> (cons_ofs == '0 || cons_ofs == $past(cons_ofs) + OW'(8))); // R5
    AST_OFS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        cons_ofs[2:0] == 3'd0); // R5
    AST_BAD_EVT_KEEP: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
        bad_evt |=> $stable(prod_ofs)); // R7
    AST_BAD_EVT_FLAG: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
        bad_evt |=> stat_bits[4]); // R7
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
        (halt_on && eng_idle) |=> $stable(cons_ofs)); // R9
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
        (!ctrl_en && eng_idle) |=> !mem_req); // R11
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R12
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R12
endmodule

bind dring_pipe dring_pipe_chk #(.AW(AW), .OW(OW)) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .reg_wen(reg_wen),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .halt_on(halt_on),
    .ctrl_en(ctrl_en), .eng_idle(eng_idle), .cons_ofs(cons_ofs),
    .prod_ofs(prod_ofs), .stat_bits(stat_bits), .mem_req(mem_req),
    .mem_ack(mem_ack), .mem_addr(mem_addr), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data)
);

// File: tb/sim_dring_pipe.sv
// Directed bench for dring_pipe: a memory model, a stream sink and a
// stream source, with one task per scenario.
module sim_dring_pipe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        tx_valid, tx_last, tx_ready = 1'b1;
    logic [31:0] tx_data;
    logic        rx_valid, rx_ready;
    logic [31:0] rx_data;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    dring_pipe u0 (.*);

    // memory model: acknowledge one cycle after a request
    logic [31:0] mem [256];
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
        end else
            mem_ack <= 1'b0;
    end

    // stream sink with optional throttling, and a hold monitor
    logic        throttle = 1'b0;
    logic [31:0] tx_log [32];
    logic        last_log [32];
    int          tx_n = 0;
    int          hold_err = 0;
    logic        pv = 1'b0, pr = 1'b0;
    logic [31:0] pd = '0;
    always @(posedge clk) begin
        if (tx_valid && tx_ready) begin
            tx_log[tx_n]   <= tx_data;
            last_log[tx_n] <= tx_last;
            tx_n           <= tx_n + 1;
        end
        if (pv && !pr && (!tx_valid || tx_data != pd)) hold_err <= hold_err + 1;
        pv <= tx_valid; pr <= tx_ready; pd <= tx_data;
        tx_ready <= throttle ? ~tx_ready : 1'b1;
    end

    // stream source
    logic [31:0] rx_q [8];
    int rx_wr = 0;
    int rx_rd = 0;
    assign rx_valid = rx_rd < rx_wr;
    assign rx_data  = rx_q[rx_rd % 8];
    always @(posedge clk) if (rx_valid && rx_ready) rx_rd <= rx_rd + 1;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h exp %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk); reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wen = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_cons(logic [31:0] exp);
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            rd(4'd8, v);
            if (v == exp) break;
        end
    endtask

    task automatic push_rx(logic [31:0] d);
        rx_q[rx_wr % 8] = d; rx_wr = rx_wr + 1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), v); chk($sformatf("R1 reg %0d after reset", a), v, 0);
        end
        chk("R1 irq", 32'(irq), 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 tx_valid", 32'(tx_valid), 0);
    endtask

    task automatic t_out();
        logic [31:0] v;
        throttle = 1'b1;
        wr(4'd5, 32'h0); wr(4'd6, 32'h20); wr(4'd4, 32'h39);
        wr(4'd0, 32'h22);
        rd(4'd0, v); chk("R3 ctrl readback", v, 32'h22);
        wr(4'd7, 32'h8);
        wait_cons(8);
        rd(4'd8, v); chk("R5 consumer after one descriptor", v, 8);
        chk("R3 beat count", 32'(tx_n), 3);
        for (int k = 0; k < 3; k++) begin
            chk($sformatf("R2 R3 beat %0d data", k), tx_log[k], 32'hA000_0000 + k);
            chk($sformatf("R3 beat %0d last", k), 32'(last_log[k]), (k == 2) ? 1 : 0);
        end
        rd(4'd3, v); chk("R8 status int+ood", v, 32'h09);
        chk("R8 irq raised", 32'(irq), 1);
        wr(4'd3, 32'h09);
        rd(4'd3, v); chk("R8 status W1C", v, 0);
        chk("R8 irq dropped", 32'(irq), 0);
        throttle = 1'b0;
    endtask

    task automatic t_in();
        logic [31:0] v;
        wr(4'd0, 32'h0A);
        push_rx(32'hC1); push_rx(32'hC2);
        wr(4'd7, 32'h10);
        wait_cons(16);
        chk("R4 word 0 in memory", mem[8'hC0], 32'hC1);
        chk("R4 word 1 in memory", mem[8'hC1], 32'hC2);
        rd(4'd3, v); chk("R8 status eot+ood", v, 32'h28);
        wr(4'd3, 32'h3F);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        wr(4'd0, 32'h02);
        wr(4'd7, 32'h18);
        wait_cons(24);
        rd(4'd8, v); chk("R6 zero-count consumer", v, 24);
        chk("R6 no stream beat", 32'(tx_n), 3);
        rd(4'd3, v); chk("R6 R8 zero-count status", v, 32'h09);
        wr(4'd3, 32'h3F);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr(4'd7, 32'h0);
        wait_cons(0);
        rd(4'd8, v); chk("R5 wrap to zero", v, 0);
        chk("R3 wrap beat count", 32'(tx_n), 4);
        chk("R3 wrap beat data", tx_log[3], 32'hB000_0000);
        chk("R3 no last without flag", 32'(last_log[3]), 0);
        rd(4'd3, v); chk("R8 ood only", v, 32'h08);
        wr(4'd3, 32'h3F);
    endtask

    task automatic t_bad();
        logic [31:0] v;
        wr(4'd7, 32'h5);
        rd(4'd3, v); chk("R7 misaligned sets error", v, 32'h10);
        rd(4'd7, v); chk("R7 misaligned ignored", v, 0);
        wr(4'd3, 32'h10);
        wr(4'd7, 32'h20);
        rd(4'd3, v); chk("R7 outside ring sets error", v, 32'h10);
        rd(4'd7, v); chk("R7 outside ring ignored", v, 0);
        chk("R8 irq on error", 32'(irq), 1);
        wr(4'd3, 32'h3F);
    endtask

    task automatic t_halt();
        logic [31:0] v;
        int base_n;
        base_n = tx_n;
        wr(4'd2, 32'h1);
        wr(4'd7, 32'h8);
        repeat (60) @(negedge clk);
        rd(4'd8, v); chk("R9 halted consumer holds", v, 0);
        chk("R9 no beats while halted", 32'(tx_n), 32'(base_n));
        wr(4'd2, 32'h0);
        wait_cons(8);
        rd(4'd8, v); chk("R9 resumed consumer", v, 8);
        chk("R9 beats after resume", 32'(tx_n), 32'(base_n + 3));
        wr(4'd3, 32'h3F);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        wr(4'd0, 32'h08);
        push_rx(32'hD1); push_rx(32'hD2);
        wr(4'd7, 32'h10);
        repeat (60) @(negedge clk);
        rd(4'd8, v); chk("R11 disabled consumer holds", v, 8);
        chk("R11 memory untouched", mem[8'hC0], 32'hC1);
        wr(4'd0, 32'h0A);
        wait_cons(16);
        chk("R11 runs once enabled", mem[8'hC0], 32'hD1);
    endtask

    task automatic t_softrst();
        logic [31:0] v;
        wr(4'd1, 32'h1);
        wr(4'd1, 32'h0);
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), v); chk($sformatf("R10 reg %0d after pipe reset", a), v, 0);
        end
        chk("R10 irq after pipe reset", 32'(irq), 0);
        chk("R12 tx hold violations", 32'(hold_err), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        mem[0] = 32'h200; mem[1] = 32'hA000_000A;   // 10 bytes, INT|EOB
        mem[2] = 32'h300; mem[3] = 32'h4000_0008;   // 8 bytes, EOT
        mem[4] = 32'h200; mem[5] = 32'h8000_0000;   // 0 bytes, INT
        mem[6] = 32'h280; mem[7] = 32'h0000_0004;   // 4 bytes, no flags
        for (int k = 0; k < 3; k++) mem[8'h80 + k] = 32'hA000_0000 + k;
        mem[8'hA0] = 32'hB000_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_out();
        t_in();
        t_zero();
        t_wrap();
        t_bad();
        t_halt();
        t_disable();
        t_softrst();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule